// File: doc/BRIEF.md
# Page Map Address Translator

This block turns a virtual address into a physical address by looking up a single-level page table held in on-chip flops. The table has one slot for every virtual page. Each slot records whether the page is present in main memory, whether it has been modified since it was brought in, and which physical frame holds it. The low bits of the virtual address are the offset within the page and pass through unchanged. The high bits select the slot.

The block keeps two independent tables, one for the kernel and one for user code. A context input picks the table for each request, so the surrounding core can switch maps on interrupt entry and return by toggling one signal. Software fills slots through a dedicated load port. A lookup that hits a non-present page raises a fault instead of producing an address. A write that hits a present page marks that page modified, so the fault handler knows it must copy the frame back before reusing it.

Lookup is combinational and the response is registered. Every request is answered exactly one clock later.

Top module: `pmap_xlate`

## Requirements
- R1: For a request to a present page, `rsp_paddr` equals the slot's frame number placed above the unchanged low `log2(PAGE_BYTES)` bits of `req_vaddr`. The frame number occupies the upper `PA_W - log2(PAGE_BYTES)` bits.
- R2: `req_ctx` = 0 selects the kernel table and `req_ctx` = 1 selects the user table. The two tables hold separate contents for the same virtual page number.
- R3: A request to a slot whose present flag is 0 gives `rsp_fault` = 1, `rsp_valid` = 0, `rsp_paddr` = 0 and `rsp_dirty` = 0. Such a request never marks the slot modified.
- R4: A write request (`req_write` = 1) to a present page sets that slot's modified flag at the same clock edge. `rsp_dirty` reports the flag as it stands after the access. A read leaves the flag unchanged.
- R5: When `sw_we` = 1, the slot addressed by `sw_ctx` and `sw_vpn` is overwritten with `sw_resident`, `sw_dirty` and `sw_ppn`. Requests in later cycles see the new contents.
- R6: `rsp_valid` / `rsp_fault` appear exactly one cycle after a request with `req_valid` = 1. Both outputs are 0 in any cycle that follows a cycle without a request.
- R7: If a software load and a hardware modified-flag update hit the same slot in the same cycle, the software load wins. The slot ends up holding exactly the loaded values.
- R8: After reset, every slot in both tables is non-present with the modified flag clear, and all response outputs are 0.
- R9: A request and a software load in the same cycle do not interact. The request is translated with the contents from before that cycle's load. A load to one context does not change the other context's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_write | input | 1 | Request is a store (1) or a load (0) |
| req_ctx | input | 1 | Table select: 0 kernel, 1 user |
| req_vaddr | input | VA_W (16) | Virtual address to translate |
| sw_we | input | 1 | Software slot load strobe |
| sw_ctx | input | 1 | Table receiving the load: 0 kernel, 1 user |
| sw_vpn | input | VA_W-log2(PAGE_BYTES) (8) | Slot index to load |
| sw_resident | input | 1 | Present flag to store |
| sw_dirty | input | 1 | Modified flag to store |
| sw_ppn | input | PA_W-log2(PAGE_BYTES) (4) | Frame number to store |
| rsp_valid | output | 1 | Registered: translation succeeded |
| rsp_fault | output | 1 | Registered: page not present |
| rsp_dirty | output | 1 | Registered: modified flag after the access |
| rsp_paddr | output | PA_W (12) | Registered physical address, 0 on a fault |

## Verification
The hardware modified-flag update and the software slot load can land on the same slot at the same clock edge. The bench provokes this by issuing a store to a present page while loading that same slot with a clean entry and a different frame. It then checks two things. The store's response must carry the old frame with the modified flag set. A read in the next cycle must show the new frame and a clear flag. The bench also makes a load and a request coincide on different contexts and on the same slot, to confirm that each context keeps only its own update.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

   typedef enum logic {
      CTX_KERNEL = 1'b0,
      CTX_USER   = 1'b1
   } ctx_e;

   localparam int unsigned NUM_CTX = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pmap_bank.sv
module pmap_bank #(
   parameter int unsigned VPN_W = 8,
   parameter int unsigned PPN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [VPN_W-1:0] sw_idx,
   input  logic             sw_res,
   input  logic             sw_dirty,
   input  logic [PPN_W-1:0] sw_ppn,
   input  logic             hw_set,
   input  logic [VPN_W-1:0] hw_idx,
   input  logic [VPN_W-1:0] rd_idx,
   output logic             rd_res,
   output logic             rd_dirty,
   output logic [PPN_W-1:0] rd_ppn
);
   localparam int unsigned DEPTH = 1 << VPN_W;

   logic             res_q   [DEPTH];
   logic             dirty_q [DEPTH];
   logic [PPN_W-1:0] ppn_q   [DEPTH];

   // software load is written last so it overrides a same-slot dirty set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            res_q[i]   <= 1'b0;
            dirty_q[i] <= 1'b0;
            ppn_q[i]   <= '0;
         end
      end else begin
         if (hw_set) begin
            dirty_q[hw_idx] <= 1'b1;
         end
         if (sw_we) begin
            res_q[sw_idx]   <= sw_res;
            dirty_q[sw_idx] <= sw_dirty;
            ppn_q[sw_idx]   <= sw_ppn;
         end
      end
   end

   assign rd_res   = res_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_ppn   = ppn_q[rd_idx];

   AST_SW_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> (ppn_q[$past(sw_idx)] == $past(sw_ppn))
             && (dirty_q[$past(sw_idx)] == $past(sw_dirty))
             && (res_q[$past(sw_idx)] == $past(sw_res))); // R7

   AST_DIRTY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set && !(sw_we && (sw_idx == hw_idx))) |=> dirty_q[$past(hw_idx)]); // R4

endmodule

// File: rtl/pmap_lookup.sv
module pmap_lookup #(
   parameter int unsigned OFS_W = 8,
   parameter int unsigned PPN_W = 4
) (
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [OFS_W-1:0]       req_ofs,
   input  logic                   ent_res,
   input  logic                   ent_dirty,
   input  logic [PPN_W-1:0]       ent_ppn,
   output logic                   hit,
   output logic                   fault,
   output logic                   dirty_out,
   output logic                   set_dirty,
   output logic [PPN_W+OFS_W-1:0] paddr
);
   always_comb begin
      hit       = req_valid && ent_res;
      fault     = req_valid && !ent_res;
      set_dirty = hit && req_write;
      dirty_out = hit && (ent_dirty || req_write);
      paddr     = hit ? {ent_ppn, req_ofs} : '0;
   end
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate #(
   parameter int unsigned VA_W       = 16,
   parameter int unsigned PA_W       = 12,
   parameter int unsigned PAGE_BYTES = 256
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 req_valid,
   input  logic                                 req_write,
   input  logic                                 req_ctx,
   input  logic [VA_W-1:0]                      req_vaddr,
   input  logic                                 sw_we,
   input  logic                                 sw_ctx,
   input  logic [VA_W-$clog2(PAGE_BYTES)-1:0]   sw_vpn,
   input  logic                                 sw_resident,
   input  logic                                 sw_dirty,
   input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]   sw_ppn,
   output logic                                 rsp_valid,
   output logic                                 rsp_fault,
   output logic                                 rsp_dirty,
   output logic [PA_W-1:0]                      rsp_paddr
);
   import pmap_pkg::*;

   localparam int unsigned OFS_W = $clog2(PAGE_BYTES);
   localparam int unsigned VPN_W = VA_W - OFS_W;
   localparam int unsigned PPN_W = PA_W - OFS_W;

   if (!is_pow2(PAGE_BYTES)) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (OFS_W >= VA_W) begin : g_chk_va
      $error("VA_W must exceed the page offset width");
   end
   if (OFS_W >= PA_W) begin : g_chk_pa
      $error("PA_W must exceed the page offset width");
   end

   ctx_e             cur_ctx;
   logic [VPN_W-1:0] req_vpn;
   logic [OFS_W-1:0] req_ofs;

   assign cur_ctx = ctx_e'(req_ctx);
   assign req_vpn = req_vaddr[VA_W-1:OFS_W];
   assign req_ofs = req_vaddr[OFS_W-1:0];

   logic [NUM_CTX-1:0]            bank_res;
   logic [NUM_CTX-1:0]            bank_dirty;
   logic [NUM_CTX-1:0][PPN_W-1:0] bank_ppn;

   logic             lk_hit, lk_fault, lk_dirty, lk_set_dirty;
   logic [PA_W-1:0]  lk_paddr;

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      localparam logic CID = 1'(g);
      pmap_bank #(
         .VPN_W (VPN_W),
         .PPN_W (PPN_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .sw_we    (sw_we && (sw_ctx == CID)),
         .sw_idx   (sw_vpn),
         .sw_res   (sw_resident),
         .sw_dirty (sw_dirty),
         .sw_ppn   (sw_ppn),
         .hw_set   (lk_set_dirty && (req_ctx == CID)),
         .hw_idx   (req_vpn),
         .rd_idx   (req_vpn),
         .rd_res   (bank_res[g]),
         .rd_dirty (bank_dirty[g]),
         .rd_ppn   (bank_ppn[g])
      );
   end

   pmap_lookup #(
      .OFS_W (OFS_W),
      .PPN_W (PPN_W)
   ) u_lookup (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ofs   (req_ofs),
      .ent_res   (bank_res[cur_ctx]),
      .ent_dirty (bank_dirty[cur_ctx]),
      .ent_ppn   (bank_ppn[cur_ctx]),
      .hit       (lk_hit),
      .fault     (lk_fault),
      .dirty_out (lk_dirty),
      .set_dirty (lk_set_dirty),
      .paddr     (lk_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_dirty <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= lk_hit;
         rsp_fault <= lk_fault;
         rsp_dirty <= lk_dirty;
         rsp_paddr <= lk_paddr;
      end
   end

   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0) && !rsp_valid && !rsp_dirty); // R3

   AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || rsp_fault) |-> $past(req_valid)); // R6

   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_valid || rsp_fault)); // R6

   AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))); // R1

endmodule

// File: tb/pmap_xlate_tb_top.sv
`timescale 1ns/1ps
module pmap_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_ctx;
   logic [15:0] req_vaddr;
   logic        sw_we, sw_ctx, sw_resident, sw_dirty;
   logic [7:0]  sw_vpn;
   logic [3:0]  sw_ppn;
   logic        rsp_valid, rsp_fault, rsp_dirty;
   logic [11:0] rsp_paddr;

   always #10 clk = ~clk;

   pmap_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_ctx(req_ctx),
      .req_vaddr(req_vaddr),
      .sw_we(sw_we), .sw_ctx(sw_ctx), .sw_vpn(sw_vpn),
      .sw_resident(sw_resident), .sw_dirty(sw_dirty), .sw_ppn(sw_ppn),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty),
      .rsp_paddr(rsp_paddr)
   );

   typedef struct {
      int          due;
      logic        v;
      logic        f;
      logic        d;
      logic [11:0] pa;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [5:0]  mdl [2][256];  // {present, modified, frame}
   int          cyc = 0;
   int          checks = 0;
   int          fails = 0;
   bit          done = 0;

   always @(posedge clk) cyc++;

   task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual v/f/d/pa=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare the scoreboard head when it falls due, else expect idle outputs
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, {rsp_valid, rsp_fault, rsp_dirty, rsp_paddr},
                {e.v, e.f, e.d, e.pa});
         end else begin
            chk("R6", {rsp_valid, rsp_fault, rsp_dirty, rsp_paddr}, 15'h0);
         end
      end
   end

   task automatic step(input logic rv, input logic rw, input logic rc,
                       input logic [15:0] va, input logic swe, input logic sc,
                       input logic [7:0] sv, input logic sr, input logic sd,
                       input logic [3:0] sp, input string tag);
      req_valid = rv; req_write = rw; req_ctx = rc; req_vaddr = va;
      sw_we = swe; sw_ctx = sc; sw_vpn = sv;
      sw_resident = sr; sw_dirty = sd; sw_ppn = sp;
      if (rv) begin
         exp_t       e;
         logic [5:0] ent;
         ent   = mdl[rc][va[15:8]];
         e.due = cyc + 1;
         e.tag = tag;
         if (ent[5]) begin
            e.v = 1'b1; e.f = 1'b0; e.d = ent[4] | rw; e.pa = {ent[3:0], va[7:0]};
            if (rw) mdl[rc][va[15:8]][4] = 1'b1;
         end else begin
            e.v = 1'b0; e.f = 1'b1; e.d = 1'b0; e.pa = 12'h0;
         end
         q.push_back(e);
      end
      if (swe) mdl[sc][sv] = {sr, sd, sp};
      @(negedge clk);
   endtask

   task automatic rd(input logic c, input logic [15:0] va, input string tag);
      step(1'b1, 1'b0, c, va, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 4'h0, tag);
   endtask

   task automatic wr(input logic c, input logic [15:0] va, input string tag);
      step(1'b1, 1'b1, c, va, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 4'h0, tag);
   endtask

   task automatic load(input logic c, input logic [7:0] vpn, input logic r,
                       input logic d, input logic [3:0] p);
      step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, c, vpn, r, d, p, "R5");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++)
         step(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 4'h0, "R6");
   endtask

   initial begin
      for (int c = 0; c < 2; c++)
         for (int v = 0; v < 256; v++) mdl[c][v] = 6'h0;
      rst_n = 1'b0;
      req_valid = 0; req_write = 0; req_ctx = 0; req_vaddr = 0;
      sw_we = 0; sw_ctx = 0; sw_vpn = 0; sw_resident = 0; sw_dirty = 0; sw_ppn = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state of outputs, and every slot starts non-present
      chk("R8", {rsp_valid, rsp_fault, rsp_dirty, rsp_paddr}, 15'h0);
      rd(1'b0, 16'h12AB, "R8");
      rd(1'b1, 16'hFF00, "R8");
      wr(1'b0, 16'h0000, "R8");

      // R1/R2/R5: per-context loads of the same page
      load(1'b0, 8'h12, 1'b1, 1'b0, 4'h5);
      load(1'b1, 8'h12, 1'b1, 1'b0, 4'h9);
      rd(1'b0, 16'h12AB, "R1");
      rd(1'b1, 16'h12AB, "R2");
      rd(1'b0, 16'h1200, "R4");
      // R4: store marks modified, only in its own context
      wr(1'b0, 16'h12FF, "R4");
      rd(1'b0, 16'h1201, "R4");
      rd(1'b1, 16'h1202, "R2");

      // R3: non-present slot with a stale frame number
      load(1'b1, 8'h40, 1'b0, 1'b1, 4'h3);
      rd(1'b1, 16'h4055, "R3");
      wr(1'b1, 16'h4055, "R3");

      // R7: store and software load on the same slot in the same cycle
      load(1'b0, 8'h20, 1'b1, 1'b0, 4'h2);
      step(1'b1, 1'b1, 1'b0, 16'h2033, 1'b1, 1'b0, 8'h20, 1'b1, 1'b0, 4'h7, "R7");
      rd(1'b0, 16'h2034, "R7");

      // R9: read sees contents from before a same-cycle load
      step(1'b1, 1'b0, 1'b0, 16'h2010, 1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 4'h1, "R9");
      rd(1'b0, 16'h2010, "R9");
      // R9: load in one context while storing to the same page in the other
      step(1'b1, 1'b1, 1'b1, 16'h1210, 1'b1, 1'b0, 8'h12, 1'b1, 1'b0, 4'h6, "R9");
      rd(1'b0, 16'h1211, "R9");
      rd(1'b1, 16'h1212, "R9");
      idle(2);

      // R1/R5: fill the whole user table, then translate back to back
      for (int v = 0; v < 256; v++)
         load(1'b1, 8'(v), 1'b1, 1'b0, 4'(v) ^ 4'hA);
      rd(1'b1, 16'h0000, "R1");
      rd(1'b1, 16'hFFFF, "R1");
      for (int v = 0; v < 256; v++) begin
         logic [7:0] ofs;
         ofs = 8'($urandom);
         if (v[0]) wr(1'b1, {8'(v), ofs}, "R4");
         else      rd(1'b1, {8'(v), ofs}, "R1");
      end
      for (int v = 1; v < 256; v += 2)
         rd(1'b1, {8'(v), 8'h5A}, "R4");
      // kernel table still mostly empty
      rd(1'b0, 16'h8000, "R3");
      rd(1'b0, 16'hFFFF, "R3");
      idle(3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL R6 watchdog: actual=hung expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule